// File: doc/BRIEF.md
# Four-Channel PWM Shared Control

This block holds the controls and flags that all four channels of a PWM peripheral share, and it steers every bus access either to one of its own registers or into the window of one channel. A host on a simple register bus starts channels with a write-one set register and stops them with a separate write-one clear register. Zero bits in either write leave channels alone, so software never has to read, modify and write back the run mask. A status register shows which channels run.

Each channel reports the end of a period, once its buffered duty value has been taken over, with a one-cycle pulse. The block collects these pulses in a sticky event register. Reading that register returns it and empties it. A pulse that arrives in the same cycle as that read is kept for the next read. Accesses at and above offset 0x200 fall into the channel windows of 0x20 bytes each. The block raises a one-hot select for the channel, passes on the offset inside the window, the strobes and the write data, and returns that channel's read data.

The address decoder sorts every access into one of six decode targets: RG_NONE (unmapped), RG_SET, RG_CLR, RG_STAT, RG_EVT and RG_CHAN. The run mask and the event mask are the only state. Both move only on the transitions named in the requirements.

Top module: `pwmg_ctrl`

## Requirements
- R1: A write to offset 0x04 sets run bit n (output ch_run[n]) for every n where write data bit n is 1; other run bits keep their value.
- R2: A write to offset 0x08 clears run bit n for every n where write data bit n is 1; other run bits keep their value.
- R3: A read of offset 0x0C returns the run mask in bits 3:0 and zero above; 0x0F means all four channels run.
- R4: A one-cycle pulse on ch_period_end[n] sets event bit n on the next clock edge, and the bit stays set until the event register is read.
- R5: A read of offset 0x1C returns the event mask in bits 3:0 (zero above) and clears every event bit at the following clock edge.
- R6: A pulse on ch_period_end[n] in the same cycle as a read of 0x1C is not returned by that read but leaves event bit n set after it.
- R7: An access to an address in 0x200 + 0x20*n to 0x21F + 0x20*n, for n in 0..3, drives ch_sel one-hot with bit n set, ch_addr equal to address bits 4:0, and ch_wr and ch_rd equal to the bus strobes. bus_rdata then equals ch_rdata bits 32n+31 to 32n. Outside these windows ch_sel is zero.
- R8: Reads of unmapped addresses and of the write-only offsets 0x04 and 0x08 return zero. Writes to unmapped addresses, to 0x0C and to 0x1C change neither the run mask nor the event mask.
- R9: After reset all run bits and all event bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| ch_period_end | input | 4 | Per-channel end-of-period pulses |
| ch_run | output | 4 | Per-channel run enables |
| ch_sel | output | 4 | One-hot channel window select |
| ch_addr | output | 5 | Offset inside the selected window |
| ch_wr | output | 1 | Write strobe into the channel window |
| ch_rd | output | 1 | Read strobe into the channel window |
| ch_wdata | output | 32 | Write data toward the channels |
| ch_rdata | input | 128 | Read data of all channels, channel n in bits 32n+31:32n |

## Verification
The set and clear registers are driven with sparse, complementary and overlapping masks, including all-zero masks. These patterns show whether zero bits are truly ignored and whether set and clear are kept apart. Event pulses are driven alone, in bursts that pile up on one another, and in the exact cycle of a clearing read. These cases separate a sticky register from a level copy and show whether the read or the event wins. Addresses on both sides of every window edge, and the unmapped addresses just outside the register map, show off-by-one errors in the decode.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned OFS_SET = 'h04;
    localparam int unsigned OFS_CLR = 'h08;
    localparam int unsigned OFS_STA = 'h0C;
    localparam int unsigned OFS_EVT = 'h1C;
    localparam int unsigned CH_BASE = 'h200;
    localparam int unsigned CH_SPAN = 'h20;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SET,
        RG_CLR,
        RG_STAT,
        RG_EVT,
        RG_CHAN
    } region_e;
endpackage

// File: rtl/pwmg_decode.sv
module pwmg_decode
    import pwmg_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic [ADDR_W-1:0]       addr,
    output region_e                 region,
    output logic [$clog2(NCH)-1:0]  ch_idx
);
    localparam int unsigned LOW_W  = $clog2(CH_SPAN);
    localparam int unsigned IDX_W  = $clog2(NCH);
    localparam int unsigned WIN_HI = CH_BASE + NCH * CH_SPAN;

    always_comb begin
        ch_idx = IDX_W'((addr - ADDR_W'(CH_BASE)) >> LOW_W);
        if (addr == ADDR_W'(OFS_SET))      region = RG_SET;
        else if (addr == ADDR_W'(OFS_CLR)) region = RG_CLR;
        else if (addr == ADDR_W'(OFS_STA)) region = RG_STAT;
        else if (addr == ADDR_W'(OFS_EVT)) region = RG_EVT;
        else if ((32'(addr) >= CH_BASE) && (32'(addr) < WIN_HI))
            region = RG_CHAN;
        else
            region = RG_NONE;
    end
endmodule

// File: rtl/pwmg_run_bank.sv
module pwmg_run_bank #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_stb,
    input  logic           clr_stb,
    input  logic [NCH-1:0] mask,
    output logic [NCH-1:0] run
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run <= '0;
        else if (set_stb) run <= run | mask;
        else if (clr_stb) run <= run & ~mask;
    end

    // R1: every requested bit is running after a set write
    p_set_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((run & $past(mask)) == $past(mask)));
    // R2: every requested bit is stopped after a clear write
    p_clr_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_stb) |=> ((run & $past(mask)) == '0));
    // R1/R2: bits outside the mask keep their value
    p_keep_other_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> ((run & ~$past(mask)) == ($past(run) & ~$past(mask))));
endmodule

// File: rtl/pwmg_evt_latch.sv
module pwmg_evt_latch #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ev_in,
    input  logic           rd_clr,
    output logic [NCH-1:0] evt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      evt <= '0;
        else if (rd_clr) evt <= ev_in;
        else             evt <= evt | ev_in;
    end

    // R4: set bits and new pulses remain set without a clearing read
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((evt & $past(evt | ev_in)) == $past(evt | ev_in)));
    // R5: a read with no coincident pulse leaves the register empty
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (ev_in == '0)) |=> (evt == '0));
    // R6: a pulse coincident with the read survives it
    p_keep_race_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((evt & $past(ev_in)) == $past(ev_in)));
endmodule

// File: rtl/pwmg_ctrl.sv
module pwmg_ctrl
    import pwmg_pkg::*;
#(
    parameter int unsigned NCH  = 4,
    parameter int unsigned DW   = 32,
    parameter int unsigned LOWW = $clog2(pwmg_pkg::CH_SPAN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 bus_rd,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NCH-1:0]       ch_period_end,
    output logic [NCH-1:0]       ch_run,
    output logic [NCH-1:0]       ch_sel,
    output logic [LOWW-1:0]      ch_addr,
    output logic                 ch_wr,
    output logic                 ch_rd,
    output logic [DW-1:0]        ch_wdata,
    input  logic [NCH*DW-1:0]    ch_rdata
);
    localparam int unsigned IDX_W = $clog2(NCH);

    region_e           region;
    logic [IDX_W-1:0]  idx;
    logic [NCH-1:0]    evt;
    logic              in_win;

    pwmg_decode #(.NCH(NCH)) u_dec (
        .addr   (bus_addr),
        .region (region),
        .ch_idx (idx)
    );

    pwmg_run_bank #(.NCH(NCH)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (bus_wr && (region == RG_SET)),
        .clr_stb (bus_wr && (region == RG_CLR)),
        .mask    (bus_wdata[NCH-1:0]),
        .run     (ch_run)
    );

    pwmg_evt_latch #(.NCH(NCH)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_in  (ch_period_end),
        .rd_clr (bus_rd && (region == RG_EVT)),
        .evt    (evt)
    );

    assign in_win   = (region == RG_CHAN);
    assign ch_addr  = bus_addr[LOWW-1:0];
    assign ch_wr    = bus_wr && in_win;
    assign ch_rd    = bus_rd && in_win;
    assign ch_wdata = bus_wdata;

    for (genvar n = 0; n < NCH; n++) begin : g_sel
        assign ch_sel[n] = in_win && (idx == IDX_W'(n));
    end

    always_comb begin
        unique case (region)
            RG_STAT: bus_rdata = DW'(ch_run);
            RG_EVT:  bus_rdata = DW'(evt);
            RG_CHAN: bus_rdata = ch_rdata[idx*DW +: DW];
            default: bus_rdata = '0;
        endcase
    end

    // R7: never more than one channel window selected
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_sel));
    // R8: writes outside the map leave the run mask alone
    p_unmapped_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (region == RG_NONE)) |=> $stable(ch_run));
endmodule

// File: tb/test_pwmg_ctrl.sv
module test_pwmg_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_rdata;
    logic [3:0]   ch_period_end = '0;
    logic [3:0]   ch_run;
    logic [3:0]   ch_sel;
    logic [4:0]   ch_addr;
    logic         ch_wr;
    logic         ch_rd;
    logic [31:0]  ch_wdata;
    logic [127:0] ch_rdata;

    int checks = 0;
    int errors = 0;
    int m_run = 0;
    int m_evt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    initial begin
        for (int n = 0; n < 4; n++)
            ch_rdata[n*32 +: 32] = 32'h1000_0000 * (n + 1) + 32'h55 + n;
    end

    pwmg_ctrl i_pwmg_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ch_period_end(ch_period_end), .ch_run(ch_run), .ch_sel(ch_sel),
        .ch_addr(ch_addr), .ch_wr(ch_wr), .ch_rd(ch_rd), .ch_wdata(ch_wdata),
        .ch_rdata(ch_rdata)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int win_of(int a);
        if (a >= 'h200 && a < 'h280) return (a - 'h200) / 'h20;
        return -1;
    endfunction

    function automatic string req_of(int a);
        if (a == 'h0C) return "R3";
        if (a == 'h1C) return "R5";
        if (win_of(a) >= 0) return "R7";
        return "R8";
    endfunction

    // one bus cycle against the behavioural model
    task automatic cyc(int a, bit wr, int wd, bit rd, int ev);
        int exp_rd;
        int w;
        @(negedge clk);
        bus_addr = 12'(a); bus_wr = wr; bus_wdata = wd; bus_rd = rd;
        ch_period_end = 4'(ev);
        #1;
        w = win_of(a);
        if (a == 'h0C) exp_rd = m_run;
        else if (a == 'h1C) exp_rd = m_evt;
        else if (w >= 0) exp_rd = ch_rdata[w*32 +: 32];
        else exp_rd = 0;
        if (rd) chk(req_of(a), bus_rdata, exp_rd);
        chk("R7 sel", ch_sel, (w >= 0) ? (1 << w) : 0);
        if (w >= 0) begin
            chk("R7 addr", ch_addr, a & 'h1F);
            chk("R7 wr", ch_wr, wr);
            chk("R7 rd", ch_rd, rd);
        end
        @(posedge clk);
        if (wr && a == 'h04) m_run = m_run | (wd & 'hF);
        else if (wr && a == 'h08) m_run = m_run & ~wd & 'hF;
        if (rd && a == 'h1C) m_evt = ev;
        else m_evt = m_evt | ev;
        #1;
        chk((a == 'h08) ? "R2" : "R1", ch_run, m_run);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #21;
        chk("R9 run", ch_run, 0);
        rst_n = 1'b1;
        cyc('h1C, 0, 0, 1, 0);              // R9: event mask empty
        cyc('h0C, 0, 0, 1, 0);              // R9/R3: run mask empty
        cyc('h04, 1, 'h5, 0, 0);            // R1 sparse set
        cyc('h04, 1, 'h0, 0, 0);            // R1 zero mask ignored
        cyc('h04, 1, 'hFFFF_FFFA, 0, 0);    // R1 complementary set
        cyc('h0C, 0, 0, 1, 0);              // R3 all on 0x0F
        cyc('h08, 1, 'h3, 0, 0);            // R2 clear low pair
        cyc('h08, 1, 'h0, 0, 0);            // R2 zero mask ignored
        cyc('h0C, 0, 0, 1, 0);              // R3
        cyc('h04, 1, 'h1, 0, 0);            // R1 overlap with running bits
        cyc('h08, 1, 'h9, 0, 0);            // R2 partial overlap
        cyc('h0C, 0, 0, 1, 0);
        cyc('h04, 0, 0, 1, 0);              // R8 write-only reads zero
        cyc('h08, 0, 0, 1, 0);              // R8
        cyc('h00, 0, 0, 0, 'h2);            // R4 single pulse
        cyc('h00, 0, 0, 0, 'h8);            // R4 accumulate
        cyc('h00, 0, 0, 0, 0);
        cyc('h1C, 0, 0, 1, 0);              // R5 returns 0xA then clears
        cyc('h1C, 0, 0, 1, 0);              // R5 empty
        cyc('h00, 0, 0, 0, 'h1);
        cyc('h1C, 0, 0, 1, 'h4);            // R6 race: returns 1, keeps 4
        cyc('h1C, 0, 0, 1, 0);              // R6 read shows 4
        cyc('h1C, 0, 0, 1, 'hF);            // R6 all channels race
        cyc('h1C, 1, 'hF, 0, 0);            // R8 write to event reg ignored
        cyc('h0C, 1, 'hF, 0, 0);            // R8 write to status ignored
        cyc('h1C, 0, 0, 1, 0);
        cyc('h0C, 0, 0, 1, 0);
        cyc('h000, 1, 'hF, 0, 0);           // R8 unmapped writes
        cyc('h1FC, 1, 'hF, 0, 0);
        cyc('h280, 1, 'hF, 0, 0);
        cyc('h0C, 0, 0, 1, 0);
        cyc('h1FC, 0, 0, 1, 0);             // R8 just below windows
        cyc('h280, 0, 0, 1, 0);             // R8 just above windows
        cyc('h10, 0, 0, 1, 0);
        for (int n = 0; n < 4; n++) begin   // R7 window edges
            cyc('h200 + n * 'h20, 0, 0, 1, 0);
            cyc('h21F + n * 'h20, 0, 0, 1, 0);
            cyc('h20C + n * 'h20, 1, 'h1234 + n, 0, 0);
            chk("R7 wdata", ch_wdata, 'h1234 + n);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule